// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional Pairs

This block keeps the single reservation that one hart holds for its load-reserved / store-conditional atomic sequences. A load-reserved request captures the aligned block of 2^GRAN_LG bytes that holds the requested address. The block is always at least one data word, so every byte of the addressed word is covered.

A store-conditional request is judged in the same cycle against that reservation. When it passes, the block raises a write enable toward memory in that cycle. One cycle later it reports a result code: zero on success, one on failure. A snoop port carries stores made by other harts. A snoop whose address falls in the reserved block kills the reservation.

The control is a two-state machine. Its states are RSV_IDLE (nothing reserved) and RSV_HELD (a block is reserved). Each cycle takes one of five named transitions:
- TR_ACQUIRE: RSV_IDLE to RSV_HELD, on a load-reserved.
- TR_REPLACE: RSV_HELD to RSV_HELD with a new block, on a load-reserved.
- TR_CONSUME: RSV_HELD to RSV_IDLE, on any store-conditional.
- TR_KILL: RSV_HELD to RSV_IDLE, on a snoop into the block, or on a load-reserved whose own block is snooped in that cycle.
- TR_STAY: no change.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no reservation is held and rsp_valid_o is low. A store-conditional issued with no load-reserved since reset fails with code 1 and does not raise sc_wr_en_o.
- R2: A load-reserved (req_valid_i high, req_is_sc_i low) reserves the block given by req_addr_i bits [ADDR_W-1:GRAN_LG]. A later store-conditional (req_is_sc_i high) to the same address succeeds with code 0.
- R3: A store-conditional to any address in the reserved block succeeds, even when that address differs from the load-reserved address. A store-conditional to an address outside the block fails with code 1.
- R4: rsp_valid_o is high for exactly one cycle, the cycle after each store-conditional request, and never after a load-reserved or an idle cycle. rsp_code_o is 0 for success and 1 for failure, and it is 0 whenever rsp_valid_o is low.
- R5: Every store-conditional consumes the reservation, whether it passes or fails. A following store-conditional with no new load-reserved fails.
- R6: A store-conditional pairs only with the newest load-reserved. A newer load-reserved replaces the older block.
- R7: A snoop (snoop_valid_i) to an address in the reserved block kills the reservation, so the next store-conditional fails. A snoop outside the block has no effect.
- R8: When a snoop into the reserved block arrives in the same cycle as a store-conditional, the snoop wins: the store-conditional fails and does not write. A snoop to another block in that cycle does not disturb the store-conditional.
- R9: When a load-reserved arrives together with a snoop into that load-reserved's own block, no reservation is established.
- R10: sc_wr_en_o is high only during the request cycle of a store-conditional that passes. It is low for load-reserved requests and for idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Reservation request from the hart this cycle |
| req_is_sc_i | input | 1 | 1 = store-conditional, 0 = load-reserved |
| req_addr_i | input | ADDR_W | Byte address of the request |
| snoop_valid_i | input | 1 | A store from another hart is observed |
| snoop_addr_i | input | ADDR_W | Byte address of the observed store |
| sc_wr_en_o | output | 1 | Memory write permitted for the current store-conditional |
| rsp_valid_o | output | 1 | Result code valid (one cycle after a store-conditional) |
| rsp_code_o | output | CODE_W | 0 = success, 1 = failure |

## Verification
The write enable is combinational on the request, so it is due in the same cycle as the store-conditional. The bench reads it a short delay after driving inputs on the falling edge. The result pulse and code pass through one register and are due in the following cycle. The bench therefore reads each step's response at the next falling edge, just before it drives the next step. This keeps every table row back to back, with no idle gap between rows. The directed reset test reads the outputs while reset is asserted and again after it is released.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [0:0] {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;

    typedef enum logic [2:0] {
        TR_STAY    = 3'd0,
        TR_ACQUIRE = 3'd1,
        TR_REPLACE = 3'd2,
        TR_CONSUME = 3'd3,
        TR_KILL    = 3'd4
    } rsv_trans_e;

    localparam int unsigned SC_PASS_CODE = 0;
    localparam int unsigned SC_FAIL_CODE = 1;

endpackage

// File: rtl/lrsc_block_match.sv
module lrsc_block_match #(
    parameter int unsigned TAG_W = 26
) (
    input  logic [TAG_W-1:0] tag_a_i,
    input  logic [TAG_W-1:0] tag_b_i,
    output logic             same_o
);
    always_comb begin
        same_o = (tag_a_i == tag_b_i);
    end
endmodule

// File: rtl/lrsc_rsv_fsm.sv
module lrsc_rsv_fsm
    import lrsc_pkg::*;
#(
    parameter int unsigned TAG_W = 26
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lr_req_i,
    input  logic             sc_req_i,
    input  logic [TAG_W-1:0] req_tag_i,
    input  logic             snoop_valid_i,
    input  logic             snoop_hits_rsv_i,
    input  logic             snoop_hits_req_i,
    input  logic             req_hits_rsv_i,
    output logic             held_o,
    output logic [TAG_W-1:0] rsv_tag_o,
    output logic             sc_pass_o
);
    rsv_state_e       state_q, state_d;
    rsv_trans_e       trans;
    logic [TAG_W-1:0] tag_q, tag_d;
    logic             rsv_killed;
    logic             lr_snooped;

    always_comb begin
        rsv_killed = snoop_valid_i && snoop_hits_rsv_i;
        lr_snooped = snoop_valid_i && snoop_hits_req_i;
    end

    // transition selection
    always_comb begin
        trans = TR_STAY;
        unique case (state_q)
            RSV_IDLE: begin
                if (lr_req_i && !lr_snooped) begin
                    trans = TR_ACQUIRE;
                end
            end
            RSV_HELD: begin
                if (sc_req_i) begin
                    trans = TR_CONSUME;
                end else if (lr_req_i) begin
                    trans = lr_snooped ? TR_KILL : TR_REPLACE;
                end else if (rsv_killed) begin
                    trans = TR_KILL;
                end
            end
            default: trans = TR_STAY;
        endcase
    end

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (trans)
            TR_ACQUIRE, TR_REPLACE: begin
                state_d = RSV_HELD;
                tag_d   = req_tag_i;
            end
            TR_CONSUME, TR_KILL: begin
                state_d = RSV_IDLE;
            end
            default: begin
                state_d = state_q;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= RSV_IDLE;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    // outputs
    always_comb begin
        held_o    = (state_q == RSV_HELD);
        rsv_tag_o = tag_q;
        sc_pass_o = 1'b0;
        unique case (state_q)
            RSV_HELD: sc_pass_o = sc_req_i && req_hits_rsv_i && !rsv_killed;
            default:  sc_pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lrsc_result_reg.sv
module lrsc_result_reg
    import lrsc_pkg::*;
#(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sc_req_i,
    input  logic              sc_pass_i,
    output logic              rsp_valid_o,
    output logic [CODE_W-1:0] rsp_code_o
);
    localparam logic [CODE_W-1:0] PASS_V = CODE_W'(SC_PASS_CODE);
    localparam logic [CODE_W-1:0] FAIL_V = CODE_W'(SC_FAIL_CODE);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_valid_o <= 1'b0;
            rsp_code_o  <= PASS_V;
        end else begin
            rsp_valid_o <= sc_req_i;
            rsp_code_o  <= (sc_req_i && !sc_pass_i) ? FAIL_V : PASS_V;
        end
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned WORD_LG = 2,
    parameter int unsigned GRAN_LG = 6,
    parameter int unsigned CODE_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_is_sc_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              snoop_valid_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    output logic              sc_wr_en_o,
    output logic              rsp_valid_o,
    output logic [CODE_W-1:0] rsp_code_o
);
    localparam int unsigned TAG_W = ADDR_W - GRAN_LG;

    generate
        if (GRAN_LG < WORD_LG || GRAN_LG >= ADDR_W) begin : g_bad_gran
            $error("GRAN_LG must lie in [WORD_LG, ADDR_W)");
        end
    endgenerate

    logic [TAG_W-1:0] req_tag, snoop_tag, rsv_tag;
    logic             lr_req, sc_req;
    logic             snoop_hits_rsv, snoop_hits_req, req_hits_rsv;
    logic             rsv_held, sc_pass;

    always_comb begin
        req_tag   = req_addr_i[ADDR_W-1:GRAN_LG];
        snoop_tag = snoop_addr_i[ADDR_W-1:GRAN_LG];
        lr_req    = req_valid_i && !req_is_sc_i;
        sc_req    = req_valid_i &&  req_is_sc_i;
    end

    lrsc_block_match #(.TAG_W(TAG_W)) u_snoop_rsv (
        .tag_a_i(snoop_tag), .tag_b_i(rsv_tag), .same_o(snoop_hits_rsv)
    );
    lrsc_block_match #(.TAG_W(TAG_W)) u_snoop_req (
        .tag_a_i(snoop_tag), .tag_b_i(req_tag), .same_o(snoop_hits_req)
    );
    lrsc_block_match #(.TAG_W(TAG_W)) u_req_rsv (
        .tag_a_i(req_tag), .tag_b_i(rsv_tag), .same_o(req_hits_rsv)
    );

    lrsc_rsv_fsm #(.TAG_W(TAG_W)) u_fsm (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .lr_req_i         (lr_req),
        .sc_req_i         (sc_req),
        .req_tag_i        (req_tag),
        .snoop_valid_i    (snoop_valid_i),
        .snoop_hits_rsv_i (snoop_hits_rsv),
        .snoop_hits_req_i (snoop_hits_req),
        .req_hits_rsv_i   (req_hits_rsv),
        .held_o           (rsv_held),
        .rsv_tag_o        (rsv_tag),
        .sc_pass_o        (sc_pass)
    );

    lrsc_result_reg #(.CODE_W(CODE_W)) u_result (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sc_req_i    (sc_req),
        .sc_pass_i   (sc_pass),
        .rsp_valid_o (rsp_valid_o),
        .rsp_code_o  (rsp_code_o)
    );

    always_comb begin
        sc_wr_en_o = sc_pass;
    end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned GRAN_LG = 6,
    parameter int unsigned CODE_W  = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              req_is_sc_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              snoop_valid_i,
    input logic [ADDR_W-1:0] snoop_addr_i,
    input logic              sc_wr_en_o,
    input logic              rsp_valid_o,
    input logic [CODE_W-1:0] rsp_code_o,
    input logic              rsv_held
);
    logic sc_now, same_blk;
    always_comb begin
        sc_now   = req_valid_i && req_is_sc_i;
        same_blk = (req_addr_i[ADDR_W-1:GRAN_LG] == snoop_addr_i[ADDR_W-1:GRAN_LG]);
    end

    // R4: a result appears only the cycle after a store-conditional
    a_r4_pulse_after_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $past(sc_now));
    // R4: code agrees with whether the write was allowed
    a_r4_code_matches_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> ((rsp_code_o == '0) == $past(sc_wr_en_o)));
    // R4: code is zero while no result is presented
    a_r4_idle_code_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsp_valid_o |-> (rsp_code_o == '0));
    // R5: any store-conditional leaves nothing reserved
    a_r5_sc_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sc_now |=> !rsv_held);
    // R1: no write without a held reservation
    a_r1_no_write_unreserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_now && !rsv_held) |-> !sc_wr_en_o);
    // R8: a same-cycle snoop into the target block blocks the write
    a_r8_snoop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_now && snoop_valid_i && same_blk) |-> !sc_wr_en_o);
    // R10: write enable only on a store-conditional request
    a_r10_write_only_on_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sc_wr_en_o |-> sc_now);
endmodule

bind lrsc_monitor lrsc_monitor_chk #(
    .ADDR_W (ADDR_W),
    .GRAN_LG(GRAN_LG),
    .CODE_W (CODE_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_is_sc_i  (req_is_sc_i),
    .req_addr_i   (req_addr_i),
    .snoop_valid_i(snoop_valid_i),
    .snoop_addr_i (snoop_addr_i),
    .sc_wr_en_o   (sc_wr_en_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_code_o   (rsp_code_o),
    .rsv_held     (rsv_held)
);

// File: tb/lrsc_monitor_tb_top.sv
module lrsc_monitor_tb_top;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CODE_W = 2;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              req_valid_i = 1'b0;
    logic              req_is_sc_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic              snoop_valid_i = 1'b0;
    logic [ADDR_W-1:0] snoop_addr_i = '0;
    logic              sc_wr_en_o;
    logic              rsp_valid_o;
    logic [CODE_W-1:0] rsp_code_o;

    int checks = 0;
    int errors = 0;

    always #2 clk_i = ~clk_i;  // 250 MHz

    lrsc_monitor #(.ADDR_W(ADDR_W), .WORD_LG(2), .GRAN_LG(6), .CODE_W(CODE_W)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_is_sc_i(req_is_sc_i),
        .req_addr_i(req_addr_i), .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
        .sc_wr_en_o(sc_wr_en_o), .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o)
    );

    // op: 0 idle, 1 load-reserved, 2 store-conditional
    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic [31:0] addr;
        logic        sv;
        logic [31:0] saddr;
        logic        wr;
        logic        rv;
        logic        code;
    } vec_t;

    localparam int N = 32;
    localparam vec_t VECS [N] = '{
        '{4'd1,  2'd2, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R1 SC with nothing reserved
        '{4'd4,  2'd0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R4 idle: no result
        '{4'd4,  2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R4 LR: no result
        '{4'd2,  2'd2, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b1, 1'b0}, // R2 SC same address passes
        '{4'd5,  2'd2, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R5 reuse after success fails
        '{4'd3,  2'd1, 32'h1008, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd2, 32'h103C, 1'b0, 32'h0,    1'b1, 1'b1, 1'b0}, // R3 other address in block
        '{4'd3,  2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd2, 32'h1040, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R3 outside block fails
        '{4'd5,  2'd2, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R5 failed SC consumed it
        '{4'd6,  2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R6
        '{4'd6,  2'd1, 32'h2000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R6 newer LR
        '{4'd6,  2'd2, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R6 old block fails
        '{4'd6,  2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R6
        '{4'd6,  2'd1, 32'h2000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R6
        '{4'd6,  2'd2, 32'h2010, 1'b0, 32'h0,    1'b1, 1'b1, 1'b0}, // R6 new block passes
        '{4'd7,  2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R7
        '{4'd7,  2'd0, 32'h0,    1'b1, 32'h1020, 1'b0, 1'b0, 1'b0}, // R7 snoop in block
        '{4'd7,  2'd2, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R7 killed
        '{4'd7,  2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R7
        '{4'd7,  2'd0, 32'h0,    1'b1, 32'h1040, 1'b0, 1'b0, 1'b0}, // R7 snoop outside
        '{4'd7,  2'd2, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b1, 1'b0}, // R7 still passes
        '{4'd8,  2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R8
        '{4'd8,  2'd2, 32'h1000, 1'b1, 32'h1004, 1'b0, 1'b1, 1'b1}, // R8 same-cycle snoop wins
        '{4'd8,  2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R8
        '{4'd8,  2'd2, 32'h1000, 1'b1, 32'h3000, 1'b1, 1'b1, 1'b0}, // R8 unrelated snoop
        '{4'd9,  2'd1, 32'h1000, 1'b1, 32'h1010, 1'b0, 1'b0, 1'b0}, // R9 LR snooped
        '{4'd9,  2'd2, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b1, 1'b1}, // R9 nothing reserved
        '{4'd10, 2'd1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R10 no write on LR
        '{4'd10, 2'd0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0}, // R10 no write idle
        '{4'd10, 2'd2, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b1, 1'b0}, // R10 write on pass
        '{4'd4,  2'd0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0}  // R4 trailing idle
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [31:0] a, input logic sv, input logic [31:0] sa);
        req_valid_i   = (op != 2'd0);
        req_is_sc_i   = (op == 2'd2);
        req_addr_i    = a;
        snoop_valid_i = sv;
        snoop_addr_i  = sa;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1", "rsp_valid_o in reset", int'(rsp_valid_o), 0);
        rst_ni = 1'b1;

        // table walk: result of row i-1 read at the falling edge where row i is driven
        for (int i = 0; i < N; i++) begin
            @(negedge clk_i);
            if (i > 0) begin
                check($sformatf("R%0d", VECS[i-1].req), "rsp_valid_o", int'(rsp_valid_o), int'(VECS[i-1].rv));
                check($sformatf("R%0d", VECS[i-1].req), "rsp_code_o", int'(rsp_code_o), int'(VECS[i-1].code));
            end
            drive(VECS[i].op, VECS[i].addr, VECS[i].sv, VECS[i].saddr);
            #1;
            check($sformatf("R%0d", VECS[i].req), "sc_wr_en_o", int'(sc_wr_en_o), int'(VECS[i].wr));
        end
        @(negedge clk_i);
        check("R4", "final rsp_valid_o", int'(rsp_valid_o), 0);

        // R1: reset drops a held reservation
        drive(2'd1, 32'h4000, 1'b0, 32'h0);
        @(negedge clk_i);
        drive(2'd0, 32'h0, 1'b0, 32'h0);
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R1", "rsp_valid_o during reset", int'(rsp_valid_o), 0);
        rst_ni = 1'b1;
        drive(2'd2, 32'h4000, 1'b0, 32'h0);
        #1;
        check("R1", "sc_wr_en_o after reset", int'(sc_wr_en_o), 0);
        @(negedge clk_i);
        drive(2'd0, 32'h0, 1'b0, 32'h0);
        check("R1", "rsp_valid_o after reset SC", int'(rsp_valid_o), 1);
        check("R1", "rsp_code_o after reset SC", int'(rsp_code_o), 1);

        // R4: back-to-back SCs each give exactly one pulse
        drive(2'd1, 32'h5000, 1'b0, 32'h0);
        @(negedge clk_i);
        drive(2'd2, 32'h5004, 1'b0, 32'h0);
        @(negedge clk_i);
        drive(2'd2, 32'h5004, 1'b0, 32'h0);
        check("R4", "first pulse", int'(rsp_valid_o), 1);
        check("R4", "first code", int'(rsp_code_o), 0);
        @(negedge clk_i);
        drive(2'd0, 32'h0, 1'b0, 32'h0);
        check("R5", "second code", int'(rsp_code_o), 1);
        @(negedge clk_i);
        check("R4", "pulse ends", int'(rsp_valid_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule